// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter

This block sits between four peripheral DMA request lines and a host processor's bus-grant handshake. When any enabled channel raises its request, the arbiter asks the host for the bus through a hold-request output. Once the host answers with hold-acknowledge, the arbiter picks one winning channel, latches it, and drives that channel's active-low acknowledge for the length of one transfer. A single-cycle transfer-done pulse from the address/data logic outside this block ends the service. The arbiter then either keeps the bus for the next pending channel or gives it back.

A five-bit mode word sets which channels may take part and which priority scheme applies. Bits 3..0 enable channels 0..3, and bit 4 selects rotating priority when 1 and fixed priority when 0. The scheme can be changed between services at run time. An asynchronous reset clears the mode word, so every channel is disabled. The reset also withdraws the control outputs, which is modelled by an output-enable signal that stays low until the first clock edge after reset is released.

The control path is a three-state machine. `S_IDLE` has no request toward the host. `S_REQ` drives hold-request and waits for hold-acknowledge. `S_SERVE` holds a latched grant. The transitions are:
- `S_IDLE -> S_REQ` on any enabled request.
- `S_REQ -> S_IDLE` when the enabled requests vanish.
- `S_REQ -> S_SERVE` when hold-acknowledge is seen while an enabled request is present.
- `S_SERVE -> S_REQ` or `S_SERVE -> S_IDLE` on transfer-done or on loss of hold-acknowledge, depending on whether any enabled request remains.

Top module: `dma_req_arbiter`

## Requirements
- R1: While `arst_n` is low, `ctl_oe` and `hold_req` are 0 and every `dack_n` bit is 1. The mode word is cleared, so after reset no request raises `hold_req` until a new mode word enables a channel.
- R2: A request on a channel whose enable bit (mode bit 3..0 for channel 0..3) is 0 is ignored. It never raises `hold_req` and never wins a grant.
- R3: From `S_IDLE`, `hold_req` goes high at the first clock edge at which an enabled request is present.
- R4: No `dack_n` bit is low unless `hold_ack` is 1. With `hold_req` high and an enabled request present, the winner's `dack_n` bit goes low at the first clock edge at which `hold_ack` is 1.
- R5: At most one `dack_n` bit is low at any time.
- R6: With mode bit 4 at 0, the lowest-numbered enabled requesting channel wins: channel 0 is highest and channel 3 is lowest.
- R7: With mode bit 4 at 1, priority rotates. The channel that last completed a transfer becomes the lowest, and the channel after it becomes the highest. After reset, channel 0 is the highest. With all four requesting, the grants run 0,1,2,3,0,...
- R8: A latched grant does not change before transfer-done, even if higher-priority requests arrive. Its `dack_n` bit returns to 1 at the clock edge where `xfer_done` is sampled high.
- R9: After transfer-done, `hold_req` stays high if any enabled request is still present. Otherwise it falls at that same edge.
- R10: If `hold_ack` falls during a service, all `dack_n` bits return to 1 combinationally in that cycle. The interrupted service does not count as completed for rotation, so the same channel wins again.
- R11: `ctl_oe` rises at the first clock edge after reset release. While it is 0, `dack_n` is all ones and `hold_req` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Mode word write strobe |
| cfg_wdata | input | 5 | Mode word: bits 3..0 channel enables, bit 4 rotating priority |
| dreq | input | 4 | Peripheral request lines, active high, bit n is channel n |
| hold_ack | input | 1 | Host has granted the bus |
| xfer_done | input | 1 | Single-cycle pulse ending the current transfer |
| hold_req | output | 1 | Bus request toward the host |
| dack_n | output | 4 | Active-low acknowledge, bit n is channel n |
| ctl_oe | output | 1 | Output enable of the control outputs (low models high impedance) |

## Verification
`hold_req` responds one clock edge after an enabled request appears or after transfer-done. A `dack_n` bit falls one edge after `hold_ack` is seen, and it returns to 1 one edge after `xfer_done` is sampled. The exceptions are the release on a `hold_ack` drop and the reset response, which are combinational and are sampled a time step after the input change. The bench drives every input on the falling clock edge. It samples results at the next falling edge, which places each check exactly one register stage after its stimulus. It uses a bench-side priority model that tracks the enable mask, the scheme and the last completed channel to predict every grant.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_REQ   = 2'd1,
        S_SERVE = 2'd2
    } svc_state_e;

endpackage

// File: rtl/dma_mode_reg.sv
module dma_mode_reg #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           arst_n,
    input  logic           we,
    input  logic [NCH:0]   wdata,
    output logic [NCH-1:0] chan_en,
    output logic           rot_mode
);

    logic [NCH:0] mode_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            mode_q <= '0;
        end else if (we) begin
            mode_q <= wdata;
        end
    end

    assign chan_en  = mode_q[NCH-1:0];
    assign rot_mode = mode_q[NCH];

endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
    parameter int NCH = 4,
    parameter int IW  = $clog2(NCH)
) (
    input  logic [NCH-1:0] elig,
    input  logic           rot_mode,
    input  logic [IW-1:0]  last_idx,
    output logic           any_elig,
    output logic [IW-1:0]  win_idx
);

    logic [IW-1:0] fixed_idx;
    logic [IW-1:0] rot_idx;

    // Fixed scheme: scan downward so the lowest index wins.
    always_comb begin
        fixed_idx = '0;
        for (int k = NCH - 1; k >= 0; k--) begin
            if (elig[k]) fixed_idx = IW'(k);
        end
    end

    // Rotating scheme: start one past the last completed channel.
    always_comb begin
        rot_idx = '0;
        for (int k = NCH - 1; k >= 0; k--) begin
            int pos;
            pos = (int'(last_idx) + 1 + k) % NCH;
            if (elig[pos]) rot_idx = IW'(pos);
        end
    end

    assign any_elig = |elig;
    assign win_idx  = rot_mode ? rot_idx : fixed_idx;

endmodule

// File: rtl/dma_svc_fsm.sv
module dma_svc_fsm
    import dma_arb_pkg::*;
#(
    parameter int NCH = 4,
    parameter int IW  = $clog2(NCH)
) (
    input  logic          clk,
    input  logic          arst_n,
    input  logic          any_elig,
    input  logic [IW-1:0] win_idx,
    input  logic          hold_ack,
    input  logic          xfer_done,
    output logic          hold_req,
    output logic          grant_vld,
    output logic [IW-1:0] grant_idx,
    output logic [IW-1:0] last_idx
);

    svc_state_e state_q, state_d;
    logic [IW-1:0] grant_q;
    logic [IW-1:0] last_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (any_elig) state_d = S_REQ;
            end
            S_REQ: begin
                if (!any_elig)     state_d = S_IDLE;
                else if (hold_ack) state_d = S_SERVE;
            end
            S_SERVE: begin
                if (xfer_done || !hold_ack) state_d = any_elig ? S_REQ : S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) state_q <= S_IDLE;
        else         state_q <= state_d;
    end

    // Grant latch and rotation pointer
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            grant_q <= '0;
            last_q  <= IW'(NCH - 1);
        end else begin
            if (state_q == S_REQ && any_elig && hold_ack) grant_q <= win_idx;
            if (state_q == S_SERVE && hold_ack && xfer_done) last_q <= grant_q;
        end
    end

    // Outputs
    always_comb begin
        hold_req  = 1'b0;
        grant_vld = 1'b0;
        unique case (state_q)
            S_IDLE:  ;
            S_REQ:   hold_req = 1'b1;
            S_SERVE: begin
                hold_req  = 1'b1;
                grant_vld = 1'b1;
            end
            default: ;
        endcase
    end

    assign grant_idx = grant_q;
    assign last_idx  = last_q;

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           arst_n,
    input  logic           cfg_we,
    input  logic [NCH:0]   cfg_wdata,
    input  logic [NCH-1:0] dreq,
    input  logic           hold_ack,
    input  logic           xfer_done,
    output logic           hold_req,
    output logic [NCH-1:0] dack_n,
    output logic           ctl_oe
);

    localparam int IW = $clog2(NCH);

    logic [NCH-1:0] chan_en;
    logic           rot_mode;
    logic           any_elig;
    logic [IW-1:0]  win_idx;
    logic [IW-1:0]  last_idx;
    logic           fsm_hold;
    logic           grant_vld;
    logic [IW-1:0]  grant_idx;
    logic           oe_q;

    dma_mode_reg #(.NCH(NCH)) u_mode (
        .clk      (clk),
        .arst_n   (arst_n),
        .we       (cfg_we),
        .wdata    (cfg_wdata),
        .chan_en  (chan_en),
        .rot_mode (rot_mode)
    );

    dma_prio_pick #(.NCH(NCH), .IW(IW)) u_pick (
        .elig     (dreq & chan_en),
        .rot_mode (rot_mode),
        .last_idx (last_idx),
        .any_elig (any_elig),
        .win_idx  (win_idx)
    );

    dma_svc_fsm #(.NCH(NCH), .IW(IW)) u_fsm (
        .clk       (clk),
        .arst_n    (arst_n),
        .any_elig  (any_elig),
        .win_idx   (win_idx),
        .hold_ack  (hold_ack),
        .xfer_done (xfer_done),
        .hold_req  (fsm_hold),
        .grant_vld (grant_vld),
        .grant_idx (grant_idx),
        .last_idx  (last_idx)
    );

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) oe_q <= 1'b0;
        else         oe_q <= 1'b1;
    end

    always_comb begin
        dack_n = '1;
        if (oe_q && grant_vld && hold_ack) dack_n[grant_idx] = 1'b0;
    end

    assign hold_req = oe_q & fsm_hold;
    assign ctl_oe   = oe_q;

endmodule

// File: rtl/dma_req_arbiter_chk.sv
module dma_req_arbiter_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           arst_n,
    input logic           hold_ack,
    input logic           xfer_done,
    input logic           hold_req,
    input logic [NCH-1:0] dack_n,
    input logic           ctl_oe,
    input logic [NCH-1:0] chan_en
);

    a_r5_one_dack: assert property (@(posedge clk) disable iff (!arst_n)
        $onehot0(~dack_n));

    a_r4_dack_needs_hold_ack: assert property (@(posedge clk) disable iff (!arst_n)
        (dack_n != '1) |-> hold_ack);

    a_r8_grant_held: assert property (@(posedge clk) disable iff (!arst_n)
        (dack_n != '1 && !xfer_done) |=> (!hold_ack || dack_n == $past(dack_n)));

    a_r8_release_on_done: assert property (@(posedge clk) disable iff (!arst_n)
        (dack_n != '1 && xfer_done) |=> (dack_n == '1));

    a_r11_oe_gates: assert property (@(posedge clk) disable iff (!arst_n)
        !ctl_oe |-> (dack_n == '1 && !hold_req));

    a_r4_dack_with_hold: assert property (@(posedge clk) disable iff (!arst_n)
        (dack_n != '1) |-> hold_req);

    always_ff @(posedge clk) begin
        if (!arst_n) begin
            a_r1_reset_state: assert (!ctl_oe && !hold_req && dack_n == '1 && chan_en == '0);
        end
    end

endmodule

bind dma_req_arbiter dma_req_arbiter_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .arst_n    (arst_n),
    .hold_ack  (hold_ack),
    .xfer_done (xfer_done),
    .hold_req  (hold_req),
    .dack_n    (dack_n),
    .ctl_oe    (ctl_oe),
    .chan_en   (chan_en)
);

// File: tb/dma_req_arbiter_tb.sv
module dma_req_arbiter_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 4;

    logic           clk = 1'b0;
    logic           arst_n = 1'b0;
    logic           cfg_we = 1'b0;
    logic [NCH:0]   cfg_wdata = '0;
    logic [NCH-1:0] dreq = '0;
    logic           hold_ack = 1'b0;
    logic           xfer_done = 1'b0;
    logic           hold_req;
    logic [NCH-1:0] dack_n;
    logic           ctl_oe;

    int nchk  = 0;
    int nfail = 0;
    bit ended = 1'b0;

    // Bench model of the mode word and rotation pointer
    logic [NCH-1:0] m_en   = '0;
    bit             m_rot  = 1'b0;
    int             m_last = NCH - 1;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dma_req_arbiter #(.NCH(NCH)) u_dut (
        .clk       (clk),
        .arst_n    (arst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .dreq      (dreq),
        .hold_ack  (hold_ack),
        .xfer_done (xfer_done),
        .hold_req  (hold_req),
        .dack_n    (dack_n),
        .ctl_oe    (ctl_oe)
    );

    function automatic int model_pick(input logic [NCH-1:0] elig);
        int start;
        start = m_rot ? (m_last + 1) % NCH : 0;
        for (int i = 0; i < NCH; i++) begin
            if (elig[(start + i) % NCH]) return (start + i) % NCH;
        end
        return -1;
    endfunction

    function automatic logic [NCH-1:0] dack_of(input int ch);
        logic [NCH-1:0] v;
        v = '1;
        v[ch] = 1'b0;
        return v;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_mode(input logic [NCH-1:0] en, input bit rot);
        cfg_we    = 1'b1;
        cfg_wdata = {rot, en};
        tick();
        cfg_we = 1'b0;
        m_en   = en;
        m_rot  = rot;
    endtask

    // One full service; keep=1 leaves all lines requesting at done.
    task automatic serve(input logic [NCH-1:0] p, input bit keep, input int want);
        int exp;
        logic [NCH-1:0] elig;
        dreq = p;
        hold_ack = 1'b0;
        elig = p & m_en;
        tick();
        chk((elig == 0) ? "R2" : "R3", 32'(hold_req), 32'(elig != 0));
        chk("R4 no dack before hold_ack", 32'(dack_n), 32'(4'hF));
        if (elig == 0) return;
        exp = model_pick(elig);
        if (want >= 0) chk(m_rot ? "R7 sequence" : "R6 order", 32'(exp), 32'(want));
        hold_ack = 1'b1;
        tick();
        chk(m_rot ? "R7" : "R6", 32'(dack_n), 32'(dack_of(exp)));
        chk("R5", 32'($countones(~dack_n)), 32'd1);
        dreq = keep ? '1 : '0;
        tick();
        chk("R8 grant held", 32'(dack_n), 32'(dack_of(exp)));
        xfer_done = 1'b1;
        tick();
        xfer_done = 1'b0;
        m_last = exp;
        chk("R8 release", 32'(dack_n), 32'(4'hF));
        chk("R9", 32'(hold_req), 32'(keep));
        dreq = '0;
        hold_ack = 1'b0;
        tick();
        chk("R9 idle", 32'(hold_req), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            nfail++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240517));
        // R1: reset state
        #1;
        chk("R1 oe", 32'(ctl_oe), 32'd0);
        chk("R1 hold", 32'(hold_req), 32'd0);
        chk("R1 dack", 32'(dack_n), 32'(4'hF));
        tick();
        tick();
        arst_n = 1'b1;
        chk("R11 oe before edge", 32'(ctl_oe), 32'd0);
        tick();
        chk("R11 oe after edge", 32'(ctl_oe), 32'd1);

        // R1/R2: cleared mode ignores everything
        serve(4'hF, 1'b0, -1);
        write_mode(4'b0101, 1'b0);
        serve(4'b1010, 1'b0, -1);

        // R6: fixed order
        write_mode(4'hF, 1'b0);
        serve(4'b1010, 1'b0, 1);
        serve(4'b1100, 1'b1, 2);
        serve(4'b1000, 1'b0, 3);
        serve(4'b1111, 1'b1, 0);
        serve(4'b1111, 1'b0, 0);

        // R1: reset in the middle of a service
        dreq = 4'hF;
        tick();
        hold_ack = 1'b1;
        tick();
        chk("R6 pre-reset grant", 32'(dack_n), 32'(dack_of(0)));
        arst_n = 1'b0;
        #1;
        chk("R1 async dack", 32'(dack_n), 32'(4'hF));
        chk("R1 async hold", 32'(hold_req), 32'd0);
        chk("R1 async oe", 32'(ctl_oe), 32'd0);
        hold_ack = 1'b0;
        m_en = '0; m_rot = 1'b0; m_last = NCH - 1;
        tick();
        arst_n = 1'b1;
        tick();
        tick();
        chk("R1 mode cleared", 32'(hold_req), 32'd0);
        dreq = '0;

        // R7: rotation over several rounds, all requesting
        write_mode(4'hF, 1'b1);
        for (int r = 0; r < 10; r++) serve(4'hF, r[0], r % NCH);

        // R10: hold_ack lost mid-service
        dreq = 4'hF;
        tick();
        hold_ack = 1'b1;
        tick();
        chk("R10 grant", 32'(dack_n), 32'(dack_of(model_pick(4'hF))));
        hold_ack = 1'b0;
        #1;
        chk("R10 release at once", 32'(dack_n), 32'(4'hF));
        tick();
        chk("R10 hold kept", 32'(hold_req), 32'd1);
        hold_ack = 1'b1;
        tick();
        chk("R10 same winner", 32'(dack_n), 32'(dack_of(model_pick(4'hF))));
        xfer_done = 1'b1;
        tick();
        xfer_done = 1'b0;
        m_last = model_pick(4'hF);
        dreq = '0;
        hold_ack = 1'b0;
        tick();

        // Random mix of modes, enables and request patterns
        for (int n = 0; n < 80; n++) begin
            if (n % 8 == 0) write_mode(NCH'($urandom()), 1'($urandom()));
            serve(NCH'($urandom()), 1'($urandom()), -1);
        end

        ended = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule